// File: doc/BRIEF.md
# Vectored 24-bit Down-Counting Timer

This block is a down-counting timer that a processor reaches through a byte-wide register port. Software loads a 24-bit preload value and a vector byte, then writes a control byte. The control byte starts the count, picks the tick source, chooses what happens at zero and decides whether a zero event raises the interrupt line. Ticks come from the module clock, either divided by a prescaler (32 by default) or taken on every clock.

Each time the counter is at zero when a tick arrives, a zero event occurs. The counter then either reloads from the preload value or wraps to all ones, and a sticky status flag is set. If an interrupt-enabled mode is selected, a level interrupt request is also raised. Software clears both the flag and the request by writing a 1 to bit 0 of the status register. While the acknowledge input is high, the read data port returns the vector byte instead of a register.

Top module: `tmr_vec_timer`

## Requirements
- R1: After reset, the control byte, preload, counter and status read 0, the vector register reads 0x0F and `timer_irq` is low.
- R2: The register map is: control at address 0, vector at 1, preload high/middle/low bytes at 2/3/4, counter high/middle/low bytes (read only) at 5/6/7, and status at 8 (bit 0 = zero flag). Control bit 3 is reserved: writes to it are stored without effect, and it always reads back as 0.
- R3: Control bit 0 enables counting. The counter decrements by one per tick only while it is set. Clearing it freezes the counter value.
- R4: A control write with bit 0 set clears the counter and the prescaler to 0 in that write cycle.
- R5: Control bits 2:1 select the tick source. 00 gives one tick every PRESCALE module clocks, 01 gives one tick every module clock, and 10 or 11 give no ticks.
- R6: With control bit 4 = 0, a tick that finds the counter at zero reloads it from the preload value.
- R7: With control bit 4 = 1, a tick that finds the counter at zero wraps it to all ones (0xFFFFFF).
- R8: Every zero event sets status bit 0.
- R9: A zero event raises `timer_irq` only when control bits 7:5 are 101 or 111. The request is a level that stays high until it is cleared.
- R10: A status write with data bit 0 = 1 clears the flag and `timer_irq`. With data bit 0 = 0 the write has no effect. If a zero event occurs in the same cycle as the clear, the event wins.
- R11: While `irq_ack` is high, `bus_rdata` returns the vector register, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_cs) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or the vector during acknowledge |
| irq_ack | input | 1 | Interrupt-acknowledge cycle |
| timer_irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with PRESCALE set to 4 instead of 32. This brings the divided tick spacing down to a few clocks, so the exact cycle of the first prescaled zero event and the spacing that follows it can be checked directly. The counter keeps its full 24-bit width, so the wrap value is the true all-ones pattern. Using a preload of zero with undivided ticks produces a zero event on every clock, which makes the clear-versus-set collision easy to force.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int CNT_BYTES = 3;
    localparam int CNT_W     = 8 * CNT_BYTES;

    localparam int A_CTRL    = 0;
    localparam int A_VEC     = 1;
    localparam int PRE_BASE  = 2;
    localparam int CNT_BASE  = PRE_BASE + CNT_BYTES;
    localparam int A_STAT    = CNT_BASE + CNT_BYTES;

    localparam logic [1:0] CLK_DIV = 2'b00;
    localparam logic [1:0] CLK_RAW = 2'b01;

    localparam logic [DATA_W-1:0] VEC_RESET = 8'h0F;

    typedef struct packed {
        logic [2:0] irq_mode;
        logic       wrap_sel;
        logic       rsvd;
        logic [1:0] clk_sel;
        logic       enable;
    } ctrl_t;

    function automatic logic irq_mode_on(input logic [2:0] mode);
        return (mode == 3'b101) || (mode == 3'b111);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic bypass,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            typedef struct packed {
                logic [PW-1:0] cnt;
            } ps_t;

            ps_t st_d, st_q;
            logic at_end;

            always_comb begin
                st_d   = st_q;
                at_end = (st_q.cnt == PW'(DIV - 1));
                tick   = run && (bypass || at_end);
                if (clr || !run || bypass) begin
                    st_d.cnt = '0;
                end else if (at_end) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + PW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             wrap_sel,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic at_zero;

    always_comb begin
        st_d     = st_q;
        at_zero  = (st_q.cnt == '0);
        zero_evt = tick && !clr && at_zero;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (at_zero) begin
                st_d.cnt = wrap_sel ? {CNT_W{1'b1}} : preload;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    input  logic [CNT_W-1:0]  count,
    input  logic              zero_evt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  preload,
    output logic              clr_cnt,
    output logic              flag,
    output logic              irq
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] vec;
        logic [CNT_W-1:0]  preload;
        logic              flag;
        logic              irq;
    } regs_t;

    regs_t st_d, st_q;
    logic  wen;
    logic  stat_clr;

    always_comb begin
        st_d     = st_q;
        wen      = bus_cs && bus_wr;
        stat_clr = wen && (int'(bus_addr) == A_STAT) && bus_wdata[0];
        clr_cnt  = wen && (int'(bus_addr) == A_CTRL) && bus_wdata[0];

        if (wen && (int'(bus_addr) == A_CTRL)) begin
            st_d.ctrl = ctrl_t'(bus_wdata);
        end
        if (wen && (int'(bus_addr) == A_VEC)) begin
            st_d.vec = bus_wdata;
        end
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (wen && (int'(bus_addr) == PRE_BASE + b)) begin
                st_d.preload[(CNT_BYTES-1-b)*8 +: 8] = bus_wdata;
            end
        end

        if (stat_clr) begin
            st_d.flag = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (zero_evt) begin
            st_d.flag = 1'b1;
            if (irq_mode_on(st_q.ctrl.irq_mode)) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.vec     <= VEC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (irq_ack) begin
            bus_rdata = st_q.vec;
        end else begin
            if (int'(bus_addr) == A_CTRL) begin
                bus_rdata = {st_q.ctrl.irq_mode, st_q.ctrl.wrap_sel, 1'b0,
                             st_q.ctrl.clk_sel, st_q.ctrl.enable};
            end
            if (int'(bus_addr) == A_VEC) begin
                bus_rdata = st_q.vec;
            end
            for (int b = 0; b < CNT_BYTES; b++) begin
                if (int'(bus_addr) == PRE_BASE + b) begin
                    bus_rdata = st_q.preload[(CNT_BYTES-1-b)*8 +: 8];
                end
                if (int'(bus_addr) == CNT_BASE + b) begin
                    bus_rdata = count[(CNT_BYTES-1-b)*8 +: 8];
                end
            end
            if (int'(bus_addr) == A_STAT) begin
                bus_rdata = {7'd0, st_q.flag};
            end
        end
    end

    assign ctrl    = st_q.ctrl;
    assign preload = st_q.preload;
    assign flag    = st_q.flag;
    assign irq     = st_q.irq;

endmodule

// File: rtl/tmr_vec_timer.sv
module tmr_vec_timer
    import tmr_pkg::*;
#(
    parameter int PRESCALE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    output logic              timer_irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] preload;
    logic [CNT_W-1:0] count;
    logic             clr_cnt;
    logic             zero_evt;
    logic             flag;
    logic             tick;
    logic             run;
    logic             bypass;

    assign bypass = (ctrl.clk_sel == CLK_RAW);
    assign run    = ctrl.enable && ((ctrl.clk_sel == CLK_DIV) || bypass);

    tmr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_ack   (irq_ack),
        .count     (count),
        .zero_evt  (zero_evt),
        .ctrl      (ctrl),
        .preload   (preload),
        .clr_cnt   (clr_cnt),
        .flag      (flag),
        .irq       (timer_irq)
    );

    tmr_prescale #(
        .DIV (PRESCALE)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_cnt),
        .run    (run),
        .bypass (bypass),
        .tick   (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cnt),
        .tick     (tick),
        .wrap_sel (ctrl.wrap_sel),
        .preload  (preload),
        .count    (count),
        .zero_evt (zero_evt)
    );

endmodule

// File: rtl/tmr_vec_timer_chk.sv
module tmr_vec_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  preload,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              clr_cnt,
    input logic              zero_evt,
    input logic              flag,
    input logic              timer_irq
);
    logic stat_clr;
    assign stat_clr = bus_cs && bus_wr && (int'(bus_addr) == A_STAT) && bus_wdata[0];

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_cnt) |=> $stable(count));

    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (count == '0));

    a_r5_no_tick_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.clk_sel[1] |-> !tick);

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !ctrl.wrap_sel) |=> (count == $past(preload)));

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && ctrl.wrap_sel) |=> (&count));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> flag);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq) |-> $past(zero_evt && irq_mode_on(ctrl.irq_mode)));

    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !stat_clr) |=> timer_irq);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !zero_evt) |=> (!flag && !timer_irq));

endmodule

bind tmr_vec_timer tmr_vec_timer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl      (ctrl),
    .preload   (preload),
    .count     (count),
    .tick      (tick),
    .clr_cnt   (clr_cnt),
    .zero_evt  (zero_evt),
    .flag      (flag),
    .timer_irq (timer_irq)
);

// File: tb/tmr_vec_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_vec_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       timer_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_vec_timer #(.PRESCALE(4)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_ack   (irq_ack),
        .timer_irq (timer_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1;
        bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a);
        #0.2;
        v = int'(bus_rdata);
    endtask

    task automatic rd_cnt(output int v);
        int h, m, l;
        rd(5, h); rd(6, m); rd(7, l);
        v = (h << 16) | (m << 8) | l;
    endtask

    task automatic t_reset;
        int v;
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 vec", v, 8'h0F);
        rd(2, v); check("R1 preload hi", v, 0);
        rd_cnt(v); check("R1 count", v, 0);
        rd(8, v); check("R1 status", v, 0);
        check("R1 irq", int'(timer_irq), 0);
    endtask

    task automatic t_regs;
        int v;
        wr(2, 8'h12); wr(3, 8'h34); wr(4, 8'h56); wr(1, 8'hA5);
        wr(0, 8'hFA);
        rd(2, v); check("R2 preload hi", v, 8'h12);
        rd(3, v); check("R2 preload mid", v, 8'h34);
        rd(4, v); check("R2 preload lo", v, 8'h56);
        rd(1, v); check("R2 vec", v, 8'hA5);
        rd(0, v); check("R2 ctrl reserved bit reads 0", v, 8'hF2);
        rd_cnt(v); check("R3 no count while disabled", v, 0);
    endtask

    task automatic t_reload_raw;
        int v, v2;
        wr(2, 0); wr(3, 0); wr(4, 5);
        wr(0, 8'h03);
        wait_clk(1);
        rd_cnt(v); check("R6 reload on zero", v, 5);
        rd(8, v); check("R8 flag set", v, 1);
        check("R9 no irq in mode 000", int'(timer_irq), 0);
        wait_clk(3);
        rd_cnt(v); check("R3 decrement per tick", v, 2);
        wr(0, 8'h02);
        rd_cnt(v);
        wait_clk(5);
        rd_cnt(v2); check("R3 freeze when disabled", v2, v);
        wr(8, 8'h00);
        rd(8, v); check("R10 write bit0=0 ignored", v, 1);
        wr(8, 8'h01);
        rd(8, v); check("R10 flag cleared", v, 0);
    endtask

    task automatic t_wrap_irq;
        int v;
        wr(0, 8'hF3);
        wait_clk(1);
        rd_cnt(v); check("R7 wrap to all ones", v, 24'hFFFFFF);
        check("R9 irq mode 111", int'(timer_irq), 1);
        wait_clk(3);
        rd_cnt(v); check("R7 count after wrap", v, 24'hFFFFFC);
        check("R9 irq held", int'(timer_irq), 1);
        irq_ack = 1'b1;
        rd(8, v); check("R11 vector on ack", v, 8'hA5);
        irq_ack = 1'b0;
        wr(8, 8'h01);
        check("R10 irq cleared", int'(timer_irq), 0);
        rd(8, v); check("R10 flag cleared", v, 0);
        wr(0, 8'hF3);
        rd_cnt(v); check("R4 enable write clears count", v, 0);
        wr(0, 8'h00);
        wr(8, 8'h01);
    endtask

    task automatic t_prescaled;
        int v;
        wr(2, 0); wr(3, 0); wr(4, 2);
        wr(0, 8'hA1);
        wait_clk(3);
        rd_cnt(v); check("R5 no tick before prescale", v, 0);
        rd(8, v); check("R5 no event yet", v, 0);
        wait_clk(1);
        rd_cnt(v); check("R5 first prescaled tick", v, 2);
        check("R9 irq mode 101", int'(timer_irq), 1);
        wait_clk(4);
        rd_cnt(v); check("R5 tick every PRESCALE", v, 1);
        wr(0, 8'h00);
        wr(8, 8'h01);
    endtask

    task automatic t_mode_off;
        int v;
        wr(0, 8'h63);
        wait_clk(1);
        rd(8, v); check("R8 flag in mode 011", v, 1);
        check("R9 no irq in mode 011", int'(timer_irq), 0);
        wr(0, 8'h00);
        wr(8, 8'h01);
    endtask

    task automatic t_no_tick_sel;
        int v;
        wr(0, 8'h05);
        wait_clk(10);
        rd_cnt(v); check("R5 clk_sel 10 no ticks", v, 0);
        rd(8, v); check("R5 no event", v, 0);
        wr(0, 8'h00);
    endtask

    task automatic t_collision;
        int v;
        wr(2, 0); wr(3, 0); wr(4, 0);
        wr(0, 8'hE3);
        wait_clk(2);
        check("R9 irq every tick", int'(timer_irq), 1);
        wr(8, 8'h01);
        rd(8, v); check("R10 event wins flag", v, 1);
        check("R10 event wins irq", int'(timer_irq), 1);
        wr(0, 8'h00);
        wr(8, 8'h01);
        rd(8, v); check("R10 final clear flag", v, 0);
        check("R10 final clear irq", int'(timer_irq), 0);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_regs();
        t_reload_raw();
        t_wrap_irq();
        t_prescaled();
        t_mode_off();
        t_no_tick_sel();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule